// File: doc/BRIEF.md
# Context-Tagged Translation Buffer with Graded Flush and Probe

This block is a small fully associative translation buffer. Each of its slots holds one leaf translation entry (a 32-bit word), the virtual tag it was filled for, the context number that was current at fill time, and the table level at which the entry was found: a 4 KiB page, a 256 KiB segment or a 16 MiB region. A combinational lookup port translates a virtual address in the current context. On a miss, an outside walker fetches the entry and writes it in through the refill port.

A command port carries maintenance operations. The operation type sits in command address bits [11:8]. A write command (flush) drops entries at one of five granularities: page, segment, region, whole context, or everything. A read command (probe) returns the cached entry for a page address one cycle later. A probe that finds nothing returns zero, which has the invalid entry type. A flush takes effect at the clock edge that accepts it. A lookup made in the same cycle as a flush therefore still sees the table as it was before the flush.

Top module: `tlb_flush_probe`

## Requirements
- R1: After reset every slot is invalid, so no lookup hits and a probe returns zero.
- R2: Refill writes the lowest-numbered invalid slot. When all slots are valid it writes the slot named by a round-robin pointer. The pointer starts at slot 0 and advances by one, wrapping after the last slot, only on such a replacement.
- R3: A lookup hits when a valid slot's context equals the current context and the virtual address matches the slot's tag at the slot's level: bits [31:12] for level 0 (page), [31:18] for level 1 (segment), [31:24] for level 2 (region). It then returns that slot's entry. With no hit, or with the lookup strobe low, hit is 0 and the entry output is zero.
- R4: A slot filled under one context never hits a lookup made under a different context.
- R5: Flush type 0 (page) drops every current-context slot whose tag matches the command address at the slot's own level. Segment and region entries that contain the page are dropped too.
- R6: Flush type 1 (segment) compares bits [31:18] for page and segment slots and bits [31:24] for region slots, within the current context.
- R7: Flush type 2 (region) drops every current-context slot whose bits [31:24] match the command address.
- R8: Flush type 3 (context) drops every slot of the current context and leaves other contexts intact.
- R9: Flush type 4 (entire) drops every slot of every context.
- R10: A flush with a type of 5 to 15 changes no slot.
- R11: A probe (read command) produces a response strobe on the cycle after it is accepted. With type 4, the data is the entry of the current-context slot that matches address bits [31:12] at its level, or zero when there is no match. Any other type returns zero.
- R12: A flush changes lookup results only from the cycle after it is accepted. A lookup in the same cycle sees the pre-flush contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_ctx | input | CTX_W | Current context number for lookup, refill, probe and scoped flushes |
| lk_valid | input | 1 | Lookup strobe |
| lk_va | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_pte | output | 32 | Entry returned on a hit, zero otherwise |
| fill_valid | input | 1 | Refill strobe |
| fill_va | input | 32 | Virtual address of the refilled entry |
| fill_lvl | input | 2 | Level of the refilled entry: 0 page, 1 segment, 2 region |
| fill_pte | input | 32 | Entry word to store |
| cmd_valid | input | 1 | Command strobe |
| cmd_probe | input | 1 | 1 = probe (read), 0 = flush (write) |
| cmd_addr | input | 32 | Command address; bits [11:8] give the type |
| rsp_valid | output | 1 | Probe response strobe |
| rsp_data | output | 32 | Probe response entry, zero on miss |

## Verification
Lookups are aimed just inside and just outside the span of each entry level. This separates a comparison made at the wrong width from a correct one. Every flush type is applied to a table that mixes page, segment and region entries across two contexts. Each slot that must survive is checked next to each slot that must go. Applying a flush under a context different from the one that owns an entry checks context scoping apart from address matching. Fill sequences that first fill the table, then overflow it, then free one slot in the middle check invalid-first placement apart from the round-robin order.

// File: rtl/tlb_flush_probe.sv
module tlb_flush_probe #(
  parameter int ENTRIES = 8,
  parameter int CTX_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CTX_W-1:0] cur_ctx,
  input  logic             lk_valid,
  input  logic [31:0]      lk_va,
  output logic             lk_hit,
  output logic [31:0]      lk_pte,
  input  logic             fill_valid,
  input  logic [31:0]      fill_va,
  input  logic [1:0]       fill_lvl,
  input  logic [31:0]      fill_pte,
  input  logic             cmd_valid,
  input  logic             cmd_probe,
  input  logic [31:0]      cmd_addr,
  output logic             rsp_valid,
  output logic [31:0]      rsp_data
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld_q;
  logic [CTX_W-1:0]   ctx_q [ENTRIES];
  logic [19:0]        tag_q [ENTRIES];
  logic [1:0]         lvl_q [ENTRIES];
  logic [31:0]        pte_q [ENTRIES];
  logic [IDX_W-1:0]   rr_q;

  function automatic logic tag_eq(input logic [19:0] t, input logic [19:0] v, input logic [1:0] lv);
    case (lv)
      2'd0:    return t == v;
      2'd1:    return t[19:6] == v[19:6];
      default: return t[19:12] == v[19:12];
    endcase
  endfunction

  function automatic logic [1:0] lmax(input logic [1:0] a, input logic [1:0] b);
    return (a > b) ? a : b;
  endfunction

  wire       do_flush = cmd_valid && !cmd_probe;
  wire [3:0] cmd_type = cmd_addr[11:8];

  logic [ENTRIES-1:0] lk_match, pr_match, kill;
  logic [31:0]        lk_or, pr_or;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    wire own = vld_q[i] && (ctx_q[i] == cur_ctx);
    assign lk_match[i] = own && tag_eq(tag_q[i], lk_va[31:12], lvl_q[i]);
    assign pr_match[i] = own && tag_eq(tag_q[i], cmd_addr[31:12], lvl_q[i]);
    always_comb begin
      case (cmd_type)
        4'd0:    kill[i] = own && tag_eq(tag_q[i], cmd_addr[31:12], lvl_q[i]);
        4'd1:    kill[i] = own && tag_eq(tag_q[i], cmd_addr[31:12], lmax(lvl_q[i], 2'd1));
        4'd2:    kill[i] = own && tag_eq(tag_q[i], cmd_addr[31:12], 2'd2);
        4'd3:    kill[i] = own;
        4'd4:    kill[i] = 1'b1;
        default: kill[i] = 1'b0;
      endcase
    end
  end

  always_comb begin
    lk_or = '0;
    pr_or = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) lk_or = lk_or | pte_q[i];
      if (pr_match[i]) pr_or = pr_or | pte_q[i];
    end
  end

  assign lk_hit = lk_valid && (|lk_match);
  assign lk_pte = lk_hit ? lk_or : '0;

  logic             have_free;
  logic [IDX_W-1:0] free_idx;
  always_comb begin
    have_free = 1'b0;
    free_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        have_free = 1'b1;
        free_idx  = IDX_W'(i);
      end
    end
  end

  wire [IDX_W-1:0] victim = have_free ? free_idx : rr_q;

  logic [ENTRIES-1:0] fill_oh;
  always_comb begin
    fill_oh = '0;
    if (fill_valid) fill_oh[victim] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q     <= '0;
      rr_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      vld_q     <= (vld_q & ~(do_flush ? kill : '0)) | fill_oh;
      if (fill_valid && !have_free) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
      rsp_valid <= cmd_valid && cmd_probe;
      rsp_data  <= (cmd_valid && cmd_probe && cmd_type == 4'd4) ? pr_or : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_valid) begin
      ctx_q[victim] <= cur_ctx;
      tag_q[victim] <= fill_va[31:12];
      lvl_q[victim] <= fill_lvl;
      pte_q[victim] <= fill_pte;
    end
  end
endmodule

module tlb_flush_probe_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        lk_valid,
  input logic        lk_hit,
  input logic [31:0] lk_pte,
  input logic        fill_valid,
  input logic        cmd_valid,
  input logic        cmd_probe,
  input logic [31:0] cmd_addr,
  input logic        rsp_valid,
  input logic [31:0] rsp_data
);
  logic filled_q, armed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filled_q <= 1'b0;
      armed_q  <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      if (fill_valid) filled_q <= 1'b1;
    end
  end

  AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n) !filled_q |-> !lk_hit); // R1
  AST_IDLE_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n) !lk_valid |-> (!lk_hit && lk_pte == 32'd0)); // R3
  AST_PROBE_TIMING: assert property (@(posedge clk) disable iff (!rst_n) armed_q |-> (rsp_valid == $past(cmd_valid && cmd_probe))); // R11
  AST_PROBE_BADTYPE: assert property (@(posedge clk) disable iff (!rst_n) (armed_q && $past(cmd_valid && cmd_probe && cmd_addr[11:8] != 4'd4)) |-> rsp_data == 32'd0); // R11
  AST_FLUSH_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) (armed_q && $past(cmd_valid && !cmd_probe && cmd_addr[11:8] == 4'd4 && !fill_valid)) |-> !lk_hit); // R9
endmodule

bind tlb_flush_probe tlb_flush_probe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_hit(lk_hit), .lk_pte(lk_pte),
  .fill_valid(fill_valid), .cmd_valid(cmd_valid), .cmd_probe(cmd_probe), .cmd_addr(cmd_addr),
  .rsp_valid(rsp_valid), .rsp_data(rsp_data)
);

// File: tb/tlb_flush_probe_test.sv
module tlb_flush_probe_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] CTX_A = 16'h0005;
  localparam logic [15:0] CTX_B = 16'h0123;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cur_ctx = CTX_A;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_va = '0;
  logic        lk_hit;
  logic [31:0] lk_pte;
  logic        fill_valid = 1'b0;
  logic [31:0] fill_va = '0;
  logic [1:0]  fill_lvl = '0;
  logic [31:0] fill_pte = '0;
  logic        cmd_valid = 1'b0;
  logic        cmd_probe = 1'b0;
  logic [31:0] cmd_addr = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_flush_probe uut (.*);

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rsp_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R11 unexpected response", rsp_data, 32'd0);
      else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(rsp_data === e, t, rsp_data, e);
      end
    end
  end

  task automatic fill(input logic [31:0] va, input logic [1:0] lv, input logic [31:0] pte);
    @(negedge clk);
    fill_valid = 1'b1; fill_va = va; fill_lvl = lv; fill_pte = pte;
    @(posedge clk); #1;
    fill_valid = 1'b0;
  endtask

  task automatic flush(input logic [31:0] addr);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_probe = 1'b0; cmd_addr = addr;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic probe(input logic [31:0] addr, input logic [31:0] exp, input string req);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_probe = 1'b1; cmd_addr = addr;
    exp_q.push_back(exp); tag_q.push_back(req);
    @(posedge clk); #1;
    cmd_valid = 1'b0; cmd_probe = 1'b0;
  endtask

  task automatic look(input logic [31:0] va, input logic hit, input logic [31:0] pte, input string req);
    @(negedge clk);
    lk_valid = 1'b1; lk_va = va;
    #1;
    check(lk_hit === hit && lk_pte === pte, req, {lk_hit, lk_pte[30:0]}, {hit, pte[30:0]});
    lk_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    look(32'h1234_5000, 1'b0, 32'd0, "R1 lookup after reset");
    probe(32'h1234_5400, 32'd0, "R1 probe after reset");

    fill(32'h1234_5000, 2'd0, 32'h0001_2302);
    fill(32'h1234_6000, 2'd0, 32'h0001_2402);
    fill(32'h1240_0000, 2'd1, 32'h0002_0002);
    fill(32'h3400_0000, 2'd2, 32'h0003_0002);
    cur_ctx = CTX_B;
    fill(32'h1234_5000, 2'd0, 32'h0009_9902);
    cur_ctx = CTX_A;

    look(32'h1234_5abc, 1'b1, 32'h0001_2302, "R3 page hit");
    look(32'h1243_F000, 1'b1, 32'h0002_0002, "R3 segment end hit");
    look(32'h1244_0000, 1'b0, 32'd0, "R3 past segment miss");
    look(32'h34FF_F123, 1'b1, 32'h0003_0002, "R3 region hit");
    look(32'h3500_0000, 1'b0, 32'd0, "R3 past region miss");
    cur_ctx = CTX_B;
    look(32'h1234_5000, 1'b1, 32'h0009_9902, "R4 other context entry");
    look(32'h1234_6000, 1'b0, 32'd0, "R4 context A entry hidden");
    cur_ctx = CTX_A;

    probe(32'h1234_6400, 32'h0001_2402, "R11 probe hit");
    probe(32'h7000_0400, 32'd0, "R11 probe miss");
    probe(32'h1234_6300, 32'd0, "R11 probe wrong type");

    flush(32'h1234_5500);
    look(32'h1234_5000, 1'b1, 32'h0001_2302, "R10 reserved flush type");

    @(negedge clk);
    cmd_valid = 1'b1; cmd_probe = 1'b0; cmd_addr = 32'h1234_5000;
    lk_valid = 1'b1; lk_va = 32'h1234_5000;
    #1 check(lk_hit === 1'b1, "R12 same-cycle lookup", {31'd0, lk_hit}, 32'd1);
    @(posedge clk); #1 cmd_valid = 1'b0;
    @(negedge clk); #1 check(lk_hit === 1'b0, "R12 next-cycle lookup", {31'd0, lk_hit}, 32'd0);
    lk_valid = 1'b0;
    look(32'h1234_6000, 1'b1, 32'h0001_2402, "R5 neighbour page kept");
    cur_ctx = CTX_B;
    look(32'h1234_5000, 1'b1, 32'h0009_9902, "R5 other context kept");
    cur_ctx = CTX_A;
    flush(32'h34AB_C000);
    look(32'h3400_0000, 1'b0, 32'd0, "R5 region entry dropped by page flush");

    fill(32'h1234_7000, 2'd0, 32'h0001_2502);
    fill(32'h5600_0000, 2'd2, 32'h0005_6002);
    flush(32'h1234_0100);
    look(32'h1234_6000, 1'b0, 32'd0, "R6 page in segment dropped");
    look(32'h1234_7000, 1'b0, 32'd0, "R6 second page dropped");
    look(32'h1240_0000, 1'b1, 32'h0002_0002, "R6 other segment kept");
    flush(32'h5678_0100);
    look(32'h5600_0000, 1'b0, 32'd0, "R6 region entry dropped by segment flush");

    flush(32'h1200_0200);
    look(32'h1241_0000, 1'b0, 32'd0, "R7 segment dropped by region flush");
    cur_ctx = CTX_B;
    look(32'h1234_5000, 1'b1, 32'h0009_9902, "R7 other context kept");
    cur_ctx = CTX_A;

    fill(32'h7000_0000, 2'd0, 32'h0007_0002);
    flush(32'h0000_0300);
    look(32'h7000_0000, 1'b0, 32'd0, "R8 context entry dropped");
    cur_ctx = CTX_B;
    look(32'h1234_5000, 1'b1, 32'h0009_9902, "R8 other context kept");
    flush(32'h0000_0400);
    look(32'h1234_5000, 1'b0, 32'd0, "R9 entire flush");
    cur_ctx = CTX_A;

    for (int i = 0; i < 8; i++) fill(32'h0800_0000 + i * 32'h1000, 2'd0, 32'h0080_0002 + i * 32'h100);
    for (int i = 0; i < 8; i++) look(32'h0800_0000 + i * 32'h1000, 1'b1, 32'h0080_0002 + i * 32'h100, "R2 full table hits");
    fill(32'h0900_0000, 2'd0, 32'h0090_0002);
    look(32'h0800_0000, 1'b0, 32'd0, "R2 slot 0 replaced");
    look(32'h0800_1000, 1'b1, 32'h0080_0102, "R2 slot 1 kept");
    look(32'h0900_0000, 1'b1, 32'h0090_0002, "R2 new entry hits");
    fill(32'h0900_1000, 2'd0, 32'h0090_0102);
    look(32'h0800_1000, 1'b0, 32'd0, "R2 round robin slot 1 replaced");
    flush(32'h0800_3000);
    fill(32'h0900_2000, 2'd0, 32'h0090_0202);
    look(32'h0800_2000, 1'b1, 32'h0080_0202, "R2 invalid slot used before pointer");
    look(32'h0900_2000, 1'b1, 32'h0090_0202, "R2 refill into freed slot");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R11 all probes answered", exp_q.size(), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule